// File: doc/BRIEF.md
# Word-Interleaved Banked Memory Crossbar

This block connects a set of processor request ports to a shared data memory split into twice as many single-ported banks as there are ports. Consecutive 32-bit words sit in consecutive banks, so streams of accesses from different processors usually land on different banks and complete together. When two or more ports reach the same bank in the same cycle, that bank's own round-robin arbiter picks one of them and the others stall.

A port raises its request with an address, an operation code, write data, byte enables and a tag. The grant comes back in the same cycle. A stalled port keeps its request unchanged until it is granted. One cycle after the grant, the port receives a response carrying its tag and the word as it was before the access. Besides reads and byte-masked writes, the bank performs an indivisible test-and-set: it returns the old word and leaves all ones behind in a single bank access.

Top module: `tcdm_xbar`

## Requirements
- R1: The address is a byte address. Bits [1:0] have no effect on bank or word selection. Bits [2 +: log2(2N)] select the bank, and the bits above them select the word inside that bank.
- R2: A request whose bank has no other requester in that cycle is granted in the same cycle. Up to N requests to N distinct banks are all granted together.
- R3: A bank grants at most one port per cycle. After port k wins a bank, priority in that bank starts at port k+1 and wraps around. After reset, port 0 has the highest priority in every bank.
- R4: A port that loses arbitration sees its grant low and holds its request. When all N ports contend for one bank, each of them is granted within N cycles.
- R5: Every granted access raises the response valid one cycle after the grant, with the request's tag and the word contents before the access. Op codes 2'b00 and 2'b11 are reads and leave the word unchanged.
- R6: Op code 2'b01 is a write. Byte-enable bit k replaces bits [8k+7:8k] of the word, and disabled bytes keep their value.
- R7: Op code 2'b10 is test-and-set. It returns the old word and writes 32'hFFFF_FFFF, ignoring write data and byte enables. When two ports test-and-set the same word in the same cycle, exactly one of them sees the prior value.
- R8: During reset, and while no port requests, no grant and no response valid are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_PORTS | Request per port |
| addr_i | input | NUM_PORTS x ADDR_W | Byte address per port |
| op_i | input | NUM_PORTS x 2 | Operation code per port |
| wdata_i | input | NUM_PORTS x 32 | Write data per port |
| be_i | input | NUM_PORTS x 4 | Byte enables per port |
| tag_i | input | NUM_PORTS x TAG_W | Request tag per port |
| gnt_o | output | NUM_PORTS | Same-cycle grant per port |
| rvalid_o | output | NUM_PORTS | Response valid per port |
| rdata_o | output | NUM_PORTS x 32 | Response word per port |
| rtag_o | output | NUM_PORTS x TAG_W | Response tag per port |

## Verification
The round-robin property assumes that a stalled port keeps presenting the same request. The lane check assumes that memory words are fully written before any partial write touches them. Both checks also take it for granted that the op code and address carry no unknown bits while a request is raised. The bench keeps within these limits by driving each port from a queue whose head stays on the pins until the reference model predicts its grant. It writes every word with all byte enables before any masked write, and it parks idle ports with their request low.

// File: rtl/tcdm_xbar_pkg.sv
package tcdm_xbar_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned BYTE_LANES  = WORD_W / 8;
  localparam int unsigned BYTE_OFFS_W = $clog2(BYTE_LANES);

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_TAS   = 2'b10,
    OP_READX = 2'b11
  } op_e;
endpackage

// File: rtl/tcdm_rr_arb.sv
module tcdm_rr_arb #(
  parameter  int unsigned NUM_REQ = 4,
  localparam int unsigned IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [IDX_W-1:0] last_q, win_d;
  logic             found;

  // search starts one past the last winner
  always_comb begin
    gnt_o = '0;
    win_d = last_q;
    found = 1'b0;
    for (int unsigned k = 1; k <= NUM_REQ; k++) begin
      int unsigned cand;
      cand = int'(last_q) + k;
      if (cand >= NUM_REQ) cand = cand - NUM_REQ;
      if (!found && req_i[cand]) begin
        gnt_o[cand] = 1'b1;
        win_d       = IDX_W'(cand);
        found       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IDX_W'(NUM_REQ - 1);
    else if (found) last_q <= win_d;
  end

  // R3
  arb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R3
  arb_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  // R2
  arb_work_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_rr
    // R3
    arb_rr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[i] |=> (!req_i[i] || $countones(req_i) < 2 || !gnt_o[i]));
  end
endmodule

// File: rtl/tcdm_bank.sv
module tcdm_bank
  import tcdm_xbar_pkg::*;
#(
  parameter  int unsigned WORDS  = 16,
  localparam int unsigned OFFS_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [1:0]            op_i,
  input  logic [OFFS_W-1:0]     offs_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  logic [BYTE_LANES-1:0] be_i,
  output logic [WORD_W-1:0]     rdata_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [WORD_W-1:0] mem_q [WORDS];
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] be_mask;
  op_e               op;

  assign op = op_e'(op_i);

  always_comb begin
    for (int unsigned k = 0; k < BYTE_LANES; k++) be_mask[8*k +: 8] = {8{be_i[k]}};
  end

  // old word always returned; test-and-set completes in the same access
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rdata_q <= mem_q[offs_i];
      case (op)
        OP_WRITE: mem_q[offs_i] <= (mem_q[offs_i] & ~be_mask) | (wdata_i & be_mask);
        OP_TAS:   mem_q[offs_i] <= '1;
        default:  ;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  // R7
  bank_tas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_TAS) |=> mem_q[$past(offs_i)] == '1);
  // R6
  bank_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_WRITE) |=>
      ((mem_q[$past(offs_i)] ^ $past(mem_q[offs_i])) & ~$past(be_mask)) == '0);
endmodule

// File: rtl/tcdm_resp_route.sv
module tcdm_resp_route
  import tcdm_xbar_pkg::*;
#(
  parameter  int unsigned NUM_BANKS = 8,
  parameter  int unsigned TAG_W     = 4,
  localparam int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              gnt_i,
  input  logic [BANK_W-1:0]                 bank_i,
  input  logic [TAG_W-1:0]                  tag_i,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_rdata_i,
  output logic                              rvalid_o,
  output logic [WORD_W-1:0]                 rdata_o,
  output logic [TAG_W-1:0]                  rtag_o
);
  timeunit 1ns; timeprecision 1ps;

  logic              valid_q;
  logic [BANK_W-1:0] bank_q;
  logic [TAG_W-1:0]  tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bank_q  <= '0;
      tag_q   <= '0;
    end else begin
      valid_q <= gnt_i;
      if (gnt_i) begin
        bank_q <= bank_i;
        tag_q  <= tag_i;
      end
    end
  end

  assign rvalid_o = valid_q;
  assign rtag_o   = tag_q;
  assign rdata_o  = bank_rdata_i[bank_q];

  // R5
  resp_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |=> rvalid_o);
  // R5
  resp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_i |=> !rvalid_o);
  // R5
  resp_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |=> rtag_o == $past(tag_i));
endmodule

// File: rtl/tcdm_xbar.sv
module tcdm_xbar
  import tcdm_xbar_pkg::*;
#(
  parameter  int unsigned NUM_PORTS  = 4,
  parameter  int unsigned BANK_WORDS = 16,
  parameter  int unsigned TAG_W      = 4,
  localparam int unsigned NUM_BANKS  = 2 * NUM_PORTS,
  localparam int unsigned BANK_W     = $clog2(NUM_BANKS),
  localparam int unsigned OFFS_W     = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1,
  localparam int unsigned ADDR_W     = BYTE_OFFS_W + BANK_W + OFFS_W
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_PORTS-1:0]                  req_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]      addr_i,
  input  logic [NUM_PORTS-1:0][1:0]             op_i,
  input  logic [NUM_PORTS-1:0][WORD_W-1:0]      wdata_i,
  input  logic [NUM_PORTS-1:0][BYTE_LANES-1:0]  be_i,
  input  logic [NUM_PORTS-1:0][TAG_W-1:0]       tag_i,
  output logic [NUM_PORTS-1:0]                  gnt_o,
  output logic [NUM_PORTS-1:0]                  rvalid_o,
  output logic [NUM_PORTS-1:0][WORD_W-1:0]      rdata_o,
  output logic [NUM_PORTS-1:0][TAG_W-1:0]       rtag_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [NUM_PORTS-1:0][BANK_W-1:0]    port_bank;
  logic [NUM_PORTS-1:0][OFFS_W-1:0]    port_offs;
  logic [NUM_BANKS-1:0][NUM_PORTS-1:0] bank_req;
  logic [NUM_BANKS-1:0][NUM_PORTS-1:0] bank_gnt;
  logic [NUM_BANKS-1:0][WORD_W-1:0]    bank_rdata;

  // word interleave: bank from low word bits, offset above
  always_comb begin
    for (int unsigned p = 0; p < NUM_PORTS; p++) begin
      port_bank[p] = addr_i[p][BYTE_OFFS_W +: BANK_W];
      port_offs[p] = addr_i[p][BYTE_OFFS_W + BANK_W +: OFFS_W];
    end
  end

  always_comb begin
    for (int unsigned b = 0; b < NUM_BANKS; b++)
      for (int unsigned p = 0; p < NUM_PORTS; p++)
        bank_req[b][p] = req_i[p] && (port_bank[p] == BANK_W'(b));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic                  en;
    logic [1:0]            op;
    logic [OFFS_W-1:0]     offs;
    logic [WORD_W-1:0]     wdata;
    logic [BYTE_LANES-1:0] be;

    tcdm_rr_arb #(.NUM_REQ(NUM_PORTS)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (bank_req[b]),
      .gnt_o  (bank_gnt[b])
    );

    always_comb begin
      en    = |bank_gnt[b];
      op    = '0;
      offs  = '0;
      wdata = '0;
      be    = '0;
      for (int unsigned p = 0; p < NUM_PORTS; p++) begin
        if (bank_gnt[b][p]) begin
          op    = op_i[p];
          offs  = port_offs[p];
          wdata = wdata_i[p];
          be    = be_i[p];
        end
      end
    end

    tcdm_bank #(.WORDS(BANK_WORDS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en),
      .op_i    (op),
      .offs_i  (offs),
      .wdata_i (wdata),
      .be_i    (be),
      .rdata_o (bank_rdata[b])
    );
  end

  always_comb begin
    gnt_o = '0;
    for (int unsigned p = 0; p < NUM_PORTS; p++)
      for (int unsigned b = 0; b < NUM_BANKS; b++)
        gnt_o[p] = gnt_o[p] | bank_gnt[b][p];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    tcdm_resp_route #(.NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W)) u_resp (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .gnt_i        (gnt_o[p]),
      .bank_i       (port_bank[p]),
      .tag_i        (tag_i[p]),
      .bank_rdata_i (bank_rdata),
      .rvalid_o     (rvalid_o[p]),
      .rdata_o      (rdata_o[p]),
      .rtag_o       (rtag_o[p])
    );

    // R2
    alone_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[p] && $countones(bank_req[port_bank[p]]) == 1) |-> gnt_o[p]);

    // R8
    idle_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i[p] |-> !gnt_o[p]);

    for (genvar j = p + 1; j < NUM_PORTS; j++) begin : g_pair
      // R3
      bank_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o[p] && gnt_o[j]) |-> port_bank[p] != port_bank[j]);
    end
  end
endmodule

// File: tb/tcdm_xbar_bench.sv
module tcdm_xbar_bench;
  timeunit 1ns; timeprecision 1ps;

  localparam int NP = 4;
  localparam int NB = 2 * NP;
  localparam int WORDS = 16;
  localparam int TW = 4;
  localparam int AW = 2 + 3 + 4;
  localparam int NW = NB * WORDS;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [NP-1:0]          req_i;
  logic [NP-1:0][AW-1:0]  addr_i;
  logic [NP-1:0][1:0]     op_i;
  logic [NP-1:0][31:0]    wdata_i;
  logic [NP-1:0][3:0]     be_i;
  logic [NP-1:0][TW-1:0]  tag_i;
  logic [NP-1:0]          gnt_o;
  logic [NP-1:0]          rvalid_o;
  logic [NP-1:0][31:0]    rdata_o;
  logic [NP-1:0][TW-1:0]  rtag_o;

  always #2 clk_i = ~clk_i;

  tcdm_xbar u_tcdm_xbar (
    .clk_i, .rst_ni, .req_i, .addr_i, .op_i, .wdata_i, .be_i, .tag_i,
    .gnt_o, .rvalid_o, .rdata_o, .rtag_o
  );

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [3:0]    be;
    logic [TW-1:0] tag;
  } op_t;

  op_t          q [NP][$];
  logic [31:0]  mem_m [NW];
  int           last_m [NB];
  logic [NP-1:0] exp_rv;
  logic [31:0]  exp_rd [NP];
  logic [TW-1:0] exp_tag [NP];
  logic [31:0]  cap_rd [NP];
  int           gcyc [NP];
  logic [TW-1:0] tag_n [NP];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string rid, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rid, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wa(input int w);
    return AW'(w << 2);
  endfunction

  function automatic int bank_of(input logic [AW-1:0] a);
    return int'(a[AW-1:2]) % NB;
  endfunction

  function automatic logic [31:0] initv(input int w);
    return {8'hC3, 8'(w), 8'(w * 3), 8'h5A};
  endfunction

  task automatic push(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [31:0] wd, input logic [3:0] be);
    op_t e;
    e.op = op; e.addr = a; e.wdata = wd; e.be = be; e.tag = tag_n[p];
    tag_n[p] = tag_n[p] + 1'b1;
    q[p].push_back(e);
  endtask

  function automatic bit all_empty();
    for (int p = 0; p < NP; p++) if (q[p].size() != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step();
    logic [NP-1:0] eg;
    op_t h;
    int w;
    @(negedge clk_i);
    cyc++;
    for (int p = 0; p < NP; p++) begin
      chk(rvalid_o[p] === exp_rv[p], "R5", "rvalid", 32'(rvalid_o[p]), 32'(exp_rv[p]));
      if (exp_rv[p]) begin
        if (!$isunknown(exp_rd[p]))
          chk(rdata_o[p] === exp_rd[p], "R5", "rdata old word", rdata_o[p], exp_rd[p]);
        chk(rtag_o[p] === exp_tag[p], "R5", "rtag", 32'(rtag_o[p]), 32'(exp_tag[p]));
        cap_rd[p] = rdata_o[p];
      end
    end
    for (int p = 0; p < NP; p++) begin
      if (q[p].size() != 0) begin
        h = q[p][0];
        req_i[p] = 1'b1; addr_i[p] = h.addr; op_i[p] = h.op;
        wdata_i[p] = h.wdata; be_i[p] = h.be; tag_i[p] = h.tag;
      end else begin
        req_i[p] = 1'b0;
      end
    end
    #1;
    eg = '0;
    for (int b = 0; b < NB; b++) begin
      bit won;
      won = 1'b0;
      for (int k = 1; k <= NP; k++) begin
        int c;
        c = (last_m[b] + k) % NP;
        if (!won && q[c].size() != 0 && bank_of(q[c][0].addr) == b) begin
          eg[c] = 1'b1; won = 1'b1; last_m[b] = c;
        end
      end
    end
    chk(gnt_o === eg, "R3", "grant vector", 32'(gnt_o), 32'(eg));
    for (int p = 0; p < NP; p++) begin
      exp_rv[p] = eg[p];
      if (eg[p]) begin
        h = q[p].pop_front();
        w = int'(h.addr[AW-1:2]);
        exp_rd[p] = mem_m[w];
        exp_tag[p] = h.tag;
        gcyc[p] = cyc;
        if (h.op == 2'b01) begin
          for (int k = 0; k < 4; k++) if (h.be[k]) mem_m[w][8*k +: 8] = h.wdata[8*k +: 8];
        end else if (h.op == 2'b10) begin
          mem_m[w] = 32'hFFFF_FFFF;
        end
      end
    end
  endtask

  task automatic run_all();
    int guard;
    guard = 0;
    while (!all_empty() && guard < 2000) begin step(); guard++; end
    step();
  endtask

  initial begin
    #(4 * 60000);
    checks++; fails++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int r1 [NP];
    int r2 [NP];
    int mn, sum, mx;
    logic [31:0] old, a, b;
    rst_ni = 1'b0;
    req_i = '0; addr_i = '0; op_i = '0; wdata_i = '0; be_i = '0; tag_i = '0;
    exp_rv = '0;
    for (int p = 0; p < NP; p++) begin tag_n[p] = '0; gcyc[p] = 0; cap_rd[p] = '0; end
    for (int b2 = 0; b2 < NB; b2++) last_m[b2] = NP - 1;
    for (int w = 0; w < NW; w++) mem_m[w] = 'x;

    repeat (3) begin
      @(negedge clk_i);
      chk(gnt_o === '0, "R8", "grant in reset", 32'(gnt_o), 0);
      chk(rvalid_o === '0, "R8", "rvalid in reset", 32'(rvalid_o), 0);
    end
    rst_ni = 1'b1;

    // R3: reset priority, all ports write word 6
    for (int p = 0; p < NP; p++) push(p, 2'b01, wa(6), 32'h6000_0000 | 32'(p), 4'hF);
    run_all();
    for (int p = 1; p < NP; p++)
      chk(gcyc[p] == gcyc[p-1] + 1, "R3", "reset priority order", 32'(gcyc[p]), 32'(gcyc[p-1] + 1));
    push(0, 2'b00, wa(6), '0, '0);
    run_all();
    chk(cap_rd[0] === 32'h6000_0003, "R3", "last writer wins", cap_rd[0], 32'h6000_0003);

    // initialise memory, full words
    for (int w = 0; w < NW; w++) push(w % NP, 2'b01, wa(w), initv(w), 4'hF);
    run_all();

    // R2: four distinct banks in one cycle
    for (int p = 0; p < NP; p++) push(p, 2'b00, wa(p), '0, '0);
    run_all();
    for (int p = 1; p < NP; p++)
      chk(gcyc[p] == gcyc[0], "R2", "parallel grant cycle", 32'(gcyc[p]), 32'(gcyc[0]));
    chk(cap_rd[2] === initv(2), "R2", "parallel read data", cap_rd[2], initv(2));

    // R1: word 8 shares bank 0 with word 0; byte bits ignored
    push(0, 2'b00, wa(0), '0, '0);
    push(1, 2'b00, wa(8), '0, '0);
    push(2, 2'b00, wa(3) | AW'(2), '0, '0);
    push(3, 2'b00, wa(3) | AW'(3), '0, '0);
    run_all();
    chk(gcyc[0] != gcyc[1], "R1", "word 0 vs word 8 conflict", 32'(gcyc[0]), 32'(gcyc[1]));
    chk(gcyc[2] != gcyc[3], "R1", "byte offsets same bank", 32'(gcyc[2]), 32'(gcyc[3]));
    chk(cap_rd[1] === initv(8), "R1", "word 8 data", cap_rd[1], initv(8));
    chk(cap_rd[3] === initv(3), "R1", "byte offset ignored", cap_rd[3], initv(3));

    // R4: all ports contend on bank 5, two rounds
    for (int p = 0; p < NP; p++) push(p, 2'b00, wa(5), '0, '0);
    run_all();
    mn = gcyc[0]; for (int p = 1; p < NP; p++) if (gcyc[p] < mn) mn = gcyc[p];
    sum = 0; mx = 0;
    for (int p = 0; p < NP; p++) begin
      r1[p] = gcyc[p] - mn; sum += r1[p]; if (r1[p] > mx) mx = r1[p];
    end
    chk(mx == NP - 1, "R4", "all granted within N cycles", 32'(mx), 32'(NP - 1));
    chk(sum == NP * (NP - 1) / 2, "R4", "one grant per cycle", 32'(sum), 32'(NP * (NP - 1) / 2));
    for (int p = 0; p < NP; p++) push(p, 2'b11, wa(5), '0, '0);
    run_all();
    mn = gcyc[0]; for (int p = 1; p < NP; p++) if (gcyc[p] < mn) mn = gcyc[p];
    for (int p = 0; p < NP; p++) begin
      r2[p] = gcyc[p] - mn;
      chk(r2[p] == r1[p], "R3", "rotation repeats", 32'(r2[p]), 32'(r1[p]));
    end
    chk(cap_rd[0] === initv(5), "R5", "op 11 reads", cap_rd[0], initv(5));

    // R6: byte enables 0101
    old = initv(10);
    push(1, 2'b01, wa(10), 32'h1122_3344, 4'b0101);
    push(1, 2'b00, wa(10), '0, '0);
    run_all();
    chk(cap_rd[1] === {old[31:24], 8'h22, old[15:8], 8'h44}, "R6", "byte lanes",
        cap_rd[1], {old[31:24], 8'h22, old[15:8], 8'h44});

    // R7: simultaneous test-and-set
    push(0, 2'b01, wa(20), 32'h0, 4'hF);
    run_all();
    push(1, 2'b10, wa(20), 32'h1234, 4'h0);
    push(2, 2'b10, wa(20), 32'h1234, 4'h0);
    run_all();
    a = cap_rd[1]; b = cap_rd[2];
    chk((a ^ b) === 32'hFFFF_FFFF, "R7", "one winner xor", a ^ b, 32'hFFFF_FFFF);
    chk(a === 32'h0 || b === 32'h0, "R7", "old value seen once", a & b, 32'h0);
    push(3, 2'b00, wa(20), '0, '0);
    run_all();
    chk(cap_rd[3] === 32'hFFFF_FFFF, "R7", "word set to ones", cap_rd[3], 32'hFFFF_FFFF);

    // random mix on a small word set
    for (int i = 0; i < 300; i++) begin
      for (int p = 0; p < NP; p++)
        if (q[p].size() == 0 && $urandom_range(1, 0) == 1)
          push(p, 2'($urandom_range(3, 0)), wa($urandom_range(15, 0)) | AW'($urandom_range(3, 0)),
               $urandom, 4'($urandom_range(15, 0)));
      step();
    end
    run_all();

    req_i = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(gnt_o === '0, "R8", "idle grant", 32'(gnt_o), 0);
    chk(rvalid_o === '0, "R8", "idle rvalid", 32'(rvalid_o), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule